// File: doc/BRIEF.md
# LIN Wake-up Pulse Transmitter

This block sends the wake-up pulse of a LIN node. Software puts the node in wake-up mode, selects the transmit direction and sets a start bit. The block then holds the transmit line low (dominant) for a programmed number of bit times and releases it to the recessive high level. The bit-time tick comes from a baud generator outside the block. In master mode a select bit can switch the block to a second tick taken from a fixed system clock, so the pulse width no longer depends on the general clock selection.

While the line is low the block reads the bus back once per bit time. If the bus reads high while it is being driven low, the pulse is cancelled and a bit-error flag is set. A pulse that ends without such a mismatch sets a done flag and, when enabled, raises a one-cycle interrupt. Both flags stay set until software clears them.

Top module: `lin_wake_tx`

## Requirements
- R1: After a synchronous active-low reset, tx_out is 1, start_bit is 0, done_flag is 0, err_flag is 0 and irq is 0.
- R2: A start request is accepted only when start_req, wake_mode and tx_dir (1 = transmit) are all 1 in the same cycle. In the following cycle tx_out is 0 and start_bit is 1. A request without all three leaves tx_out at 1 and start_bit at 0.
- R3: width_code is a 4-bit field captured when the start is accepted. The pulse ends on the (width_code+1)-th bit tick after the start, so codes 0 to 15 give 1 to 16 bit times. Code 0100b gives 5 bit times.
- R4: In the cycle after the pulse ends, whether it completed or was cancelled, tx_out is back at 1 and start_bit reads 0.
- R5: On every bit tick while the pulse is active, rx_in is sampled. A sampled 1 ends the pulse on that tick and sets err_flag. An error takes priority over completion on the same tick.
- R6: A pulse that reaches its width with every sample low sets done_flag and leaves err_flag unchanged.
- R7: When done_flag is set and irq_en is 1, irq is 1 for exactly one cycle, in the same cycle that done_flag first reads 1. irq stays 0 when irq_en is 0 and when the pulse is cancelled.
- R8: A start request made while a pulse is active is ignored. The captured width and the pulse length do not change.
- R9: done_flag and err_flag stay set until a 1 is written to done_clr or err_clr. Each clear affects only its own flag.
- R10: The bit tick is tick_fixed when master_mode and fixed_clk_sel are both 1. Otherwise it is tick_gen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_gen | input | 1 | Bit-time tick from the general clock selection |
| tick_fixed | input | 1 | Bit-time tick from the fixed system clock |
| master_mode | input | 1 | Node operates as master |
| fixed_clk_sel | input | 1 | In master mode, take the bit time from tick_fixed |
| wake_mode | input | 1 | Block is in wake-up mode |
| tx_dir | input | 1 | Direction, 1 = transmit |
| start_req | input | 1 | Write of 1 to the start bit |
| width_code | input | WB | Low width code, width = code + 1 bit times |
| irq_en | input | 1 | Enable for the completion interrupt |
| done_clr | input | 1 | Write-1 clear of done_flag |
| err_clr | input | 1 | Write-1 clear of err_flag |
| rx_in | input | 1 | Received bus level |
| tx_out | output | 1 | Transmit line, idles high |
| start_bit | output | 1 | Start bit readback, 1 while the pulse is active |
| done_flag | output | 1 | Clean completion flag |
| err_flag | output | 1 | Bit-error flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with the default 4-bit width field. This covers every code from 0 to 15, including the 1-bit and 16-bit extremes and the 5-bit-time case. Tick spacing is randomized between one and six clocks. The unselected tick input is held high on every cycle, so choosing the wrong tick source shortens the pulse in a way the bench can see. Random error placement covers cancellation on the first tick, on the last tick and on ticks in between.

// File: rtl/lin_wake_tx.sv
module lin_wake_tx #(
  parameter int WB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_gen,
  input  logic          tick_fixed,
  input  logic          master_mode,
  input  logic          fixed_clk_sel,
  input  logic          wake_mode,
  input  logic          tx_dir,
  input  logic          start_req,
  input  logic [WB-1:0] width_code,
  input  logic          irq_en,
  input  logic          done_clr,
  input  logic          err_clr,
  input  logic          rx_in,
  output logic          tx_out,
  output logic          start_bit,
  output logic          done_flag,
  output logic          err_flag,
  output logic          irq
);

  logic          busy;
  logic [WB-1:0] cnt;
  logic [WB-1:0] wlen;
  logic          done_q;
  logic          err_q;
  logic          irq_q;

  wire tick = (master_mode && fixed_clk_sel) ? tick_fixed : tick_gen;
  wire go   = start_req && wake_mode && tx_dir && !busy;
  wire chk  = busy && tick;
  wire bad  = chk && rx_in;
  wire fin  = chk && !rx_in && (cnt == wlen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      wlen   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fin && irq_en;
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
        wlen <= width_code;
      end else if (bad || fin) begin
        busy <= 1'b0;
      end else if (chk) begin
        cnt <= cnt + 1'b1;
      end
      if (fin)           done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (bad)           err_q <= 1'b1;
      else if (err_clr)  err_q <= 1'b0;
    end
  end

  assign tx_out    = ~busy;
  assign start_bit = busy;
  assign done_flag = done_q;
  assign err_flag  = err_q;
  assign irq       = irq_q;

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

  // R8
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && !tick) |=> start_bit);

  // R3
  width_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && $past(start_bit)) |-> $stable(wlen));

  // R5
  err_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && tick && rx_in) |=> (err_flag && tx_out));

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_bit && tick && !rx_in && cnt == wlen) |=> (done_flag && tx_out));

endmodule

// File: tb/tb_lin_wake_tx.sv
`timescale 1ns/1ps
module tb_lin_wake_tx;
  logic clk = 0, rst_n = 0;
  logic tick_gen = 0, tick_fixed = 0, master_mode = 0, fixed_clk_sel = 0;
  logic wake_mode = 0, tx_dir = 0, start_req = 0, irq_en = 0;
  logic done_clr = 0, err_clr = 0, rx_in = 1;
  logic [3:0] width_code = 0;
  logic tx_out, start_bit, done_flag, err_flag, irq;

  int vectors = 0, miscompares = 0;

  lin_wake_tx #(.WB(4)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int w, input int et);
    return (et >= 0) ? et + 1 : w + 1;
  endfunction

  task automatic clear_flags();
    @(negedge clk); done_clr = 1; err_clr = 1;
    @(negedge clk); done_clr = 0; err_clr = 0;
  endtask

  task automatic do_pulse(input int w, input int per, input int et,
                          input bit ien, input bit fix, input int restart);
    int ticks = 0, irqs = 0, cyc = 0;
    bit tk, was_busy;
    clear_flags();
    master_mode = fix; fixed_clk_sel = fix;
    wake_mode = 1; tx_dir = 1; irq_en = ien;
    width_code = 4'(w); start_req = 1;
    @(negedge clk); start_req = 0;
    check("R2 start_bit", start_bit, 1);
    check("R2 tx low", tx_out, 0);
    while (start_bit && cyc < 400) begin
      tk = ((cyc % per) == per - 1);
      was_busy = start_bit;
      if (fix) begin tick_fixed = tk; tick_gen = 1; end
      else begin tick_gen = tk; tick_fixed = 1; end
      rx_in = (tk && ticks == et) ? 1'b1 : tx_out;
      start_req = (cyc == restart);
      if (cyc == restart) width_code = 4'(15 - w);
      @(negedge clk);
      if (tk && was_busy) ticks++;
      if (irq) irqs++;
      if (start_bit && tx_out) check("R2 tx low while active", tx_out, 0);
      cyc++;
    end
    tick_gen = 0; tick_fixed = 0; start_req = 0; rx_in = 1;
    check(restart >= 0 ? "R8 length with restart" : (fix ? "R10 tick select" : "R3 width"),
          ticks, exp_ticks(w, et));
    check("R4 tx high", tx_out, 1);
    check("R4 start_bit low", start_bit, 0);
    check("R5 err_flag", err_flag, et >= 0);
    check("R6 done_flag", done_flag, et < 0);
    check("R7 irq count", irqs, (et < 0 && ien) ? 1 : 0);
    @(negedge clk);
    check("R7 irq one cycle", irq, 0);
    check("R9 flags sticky", done_flag + 2 * err_flag, (et < 0) ? 1 : 2);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    check("R1 tx", tx_out, 1);
    check("R1 start_bit", start_bit, 0);
    check("R1 flags", done_flag + err_flag + irq, 0);
    rst_n = 1;
    @(negedge clk);

    wake_mode = 0; tx_dir = 1; start_req = 1;
    @(negedge clk); start_req = 0;
    @(negedge clk);
    check("R2 no start without wake mode", start_bit + 2 * (1 - tx_out), 0);
    wake_mode = 1; tx_dir = 0; start_req = 1;
    @(negedge clk); start_req = 0;
    @(negedge clk);
    check("R2 no start without tx direction", start_bit + 2 * (1 - tx_out), 0);

    do_pulse(4, 3, -1, 1, 0, -1);
    do_pulse(0, 1, -1, 1, 0, -1);
    do_pulse(15, 2, -1, 0, 0, -1);
    do_pulse(6, 2, 0, 1, 0, -1);
    do_pulse(6, 2, 6, 1, 0, -1);
    do_pulse(3, 4, -1, 1, 1, -1);
    do_pulse(5, 2, -1, 1, 0, 3);

    // R9 individual clears
    do_pulse(2, 1, -1, 0, 0, -1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    check("R9 err_clr leaves done", done_flag, 1);
    done_clr = 1;
    @(negedge clk); done_clr = 0;
    check("R9 done_clr clears", done_flag, 0);

    for (int i = 0; i < 40; i++) begin
      int w = $urandom_range(0, 15);
      int per = $urandom_range(1, 6);
      int et = ($urandom_range(0, 3) == 0) ? $urandom_range(0, w) : -1;
      do_pulse(w, per, et, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 3) == 0) ? $urandom_range(0, 5) : -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule